// File: doc/BRIEF.md
# Counter Wrap Extender

This block turns a free-running 32-bit counter into a 64-bit timestamp. It keeps a 32-bit high word in a register. It also keeps the low value it saw on the last sample. Whenever a new low value is sampled and turns out smaller than the stored one, the counter is taken to have wrapped, and the high word advances by one.

Samples come from two places. A periodic tick input updates the tracking state and produces no response; its job is to keep wraps from going unseen when software reads rarely. A read request also samples, and one cycle later it returns the 64-bit value, built from the updated high word and the very low value that was just compared. The high word stays correct only while some sample, from either source, lands at least once per counter wrap period. While the counter is reported as not started, a read returns zero and the tracking state is left alone.

Top module: `ts_wrap_ext`

## Requirements
- R1: After reset, rd_valid_o is 0, rd_data_o is 0, the high word is 0 and no previous sample is held.
- R2: The first sample after reset only stores the low value and marks it valid. It never increments the high word, so a first read of low value L returns {32'h0, L}.
- R3: On a sample with a stored previous value, the high word increments by exactly one when the previous low value is strictly greater than the current low value. Equal or larger current values leave it unchanged.
- R4: A read taken while run_i is 1 returns {high, low}. Here low is cnt_low_i in the request cycle, and high already includes any increment caused by comparing that same low value. The high word sits in bits 63:32 and the low word in bits 31:0.
- R5: A tick on its own samples and runs the wrap check, which updates the high word and the stored value, but it produces no rd_valid_o pulse.
- R6: A tick and a read in the same cycle share one capture and one wrap check, so a single wrap is counted once.
- R7: While run_i is 0, a read returns 0 with a normal valid pulse. Ticks and reads in that state change neither the high word nor the stored sample.
- R8: rd_valid_o is 1 in exactly the cycle after each cycle in which rd_req_i is 1, and 0 otherwise. rd_data_o holds its value between responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counter has been started |
| cnt_low_i | input | 32 | Current value of the free-running counter |
| tick_i | input | 1 | Periodic tick sample request |
| rd_req_i | input | 1 | On-demand read request |
| rd_valid_o | output | 1 | One-cycle response strobe |
| rd_data_o | output | 64 | Composed 64-bit timestamp |

## Verification
The tick sample and the read request can fall in the same cycle. That cycle is the one where a double-counted wrap would show up. The bench drives both together on a value below the stored sample, both as a directed case and at random during the mixed run. It then checks that the returned high word advanced by exactly one, and that a later read does not advance it again. Every response is compared against a reference model that applies the compare-then-compose rule once per cycle, whichever sources are active.

// File: rtl/ts_wrap_pkg.sv
package ts_wrap_pkg;
  localparam int unsigned LOW_W_DEF = 32;
  localparam int unsigned HI_W_DEF  = 32;

  typedef struct packed {
    logic en;    // capture and wrap check this cycle
    logic rsp;   // a response is owed next cycle
    logic zero;  // response must be zero (counter idle)
  } sample_ctl_t;
endpackage

// File: rtl/ts_wrap_sample.sv
module ts_wrap_sample
  import ts_wrap_pkg::*;
(
  input  logic        tick_i,
  input  logic        rd_req_i,
  input  logic        run_i,
  output sample_ctl_t ctl_o
);
  // Both sources merge into one sample strobe: one capture per cycle.
  always_comb begin
    ctl_o.en   = (tick_i | rd_req_i) & run_i;
    ctl_o.rsp  = rd_req_i;
    ctl_o.zero = ~run_i;
  end
endmodule

// File: rtl/ts_wrap_track.sv
module ts_wrap_track #(
  parameter int unsigned LOW_W = 32,
  parameter int unsigned HI_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LOW_W-1:0] low_i,
  output logic [HI_W-1:0]  hi_now_o
);
  localparam logic [HI_W-1:0] HI_ONE = {{(HI_W-1){1'b0}}, 1'b1};

  logic [HI_W-1:0]  hi_q;
  logic [LOW_W-1:0] prev_q;
  logic             vld_q;
  logic             wrap;

  assign wrap     = en_i & vld_q & (prev_q > low_i);
  assign hi_now_o = wrap ? hi_q + HI_ONE : hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else if (en_i) begin
      hi_q   <= hi_now_o;
      prev_q <= low_i;
      vld_q  <= 1'b1;
    end
  end

  // R2
  first_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !vld_q) |=> (hi_q == $past(hi_q)) && vld_q);

  // R3
  wrap_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && vld_q && (prev_q > low_i)) |=> (hi_q == $past(hi_q) + HI_ONE));

  // R3
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && vld_q && (prev_q <= low_i)) |=> (hi_q == $past(hi_q)));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(hi_q) && $stable(prev_q) && $stable(vld_q)));
endmodule

// File: rtl/ts_wrap_resp.sv
module ts_wrap_resp #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rsp_i,
  input  logic         zero_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= rsp_i;
      if (rsp_i) data_o <= zero_i ? '0 : data_i;
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_i |=> $stable(data_o));
endmodule

// File: rtl/ts_wrap_ext.sv
module ts_wrap_ext
  import ts_wrap_pkg::*;
#(
  parameter int unsigned LOW_W = LOW_W_DEF,
  parameter int unsigned HI_W  = HI_W_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic [LOW_W-1:0]      cnt_low_i,
  input  logic                  tick_i,
  input  logic                  rd_req_i,
  output logic                  rd_valid_o,
  output logic [LOW_W+HI_W-1:0] rd_data_o
);
  localparam int unsigned TS_W = LOW_W + HI_W;

  sample_ctl_t     ctl;
  logic [HI_W-1:0] hi_now;
  logic [TS_W-1:0] ts_comb;

  ts_wrap_sample u_sample (
    .tick_i   (tick_i),
    .rd_req_i (rd_req_i),
    .run_i    (run_i),
    .ctl_o    (ctl)
  );

  ts_wrap_track #(.LOW_W(LOW_W), .HI_W(HI_W)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctl.en),
    .low_i    (cnt_low_i),
    .hi_now_o (hi_now)
  );

  // Compose from the same captured low value that was compared.
  assign ts_comb = {hi_now, cnt_low_i};

  ts_wrap_resp #(.W(TS_W)) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rsp_i   (ctl.rsp),
    .zero_i  (ctl.zero),
    .data_i  (ts_comb),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );

  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);

  // R8
  no_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o);

  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !run_i) |=> (rd_data_o == '0));

  // R4
  low_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && run_i) |=> (rd_data_o[LOW_W-1:0] == $past(cnt_low_i)));
endmodule

// File: tb/sim_ts_wrap_ext.sv
module sim_ts_wrap_ext;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [31:0] cnt_low_i = '0;
  logic        tick_i = 1'b0;
  logic        rd_req_i = 1'b0;
  logic        rd_valid_o;
  logic [63:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_hi = '0;
  logic [31:0] m_prev = '0;
  logic        m_vld = 1'b0;
  logic [63:0] m_last = '0;

  always #5 clk_i = ~clk_i;

  ts_wrap_ext u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .cnt_low_i(cnt_low_i),
    .tick_i(tick_i), .rd_req_i(rd_req_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference: one capture/compare per cycle, compose after the compare.
  function automatic logic [63:0] model(input logic t, input logic r,
                                        input logic run, input logic [31:0] low);
    if ((t || r) && run) begin
      if (m_vld && m_prev > low) m_hi = m_hi + 32'd1;
      m_prev = low;
      m_vld  = 1'b1;
    end
    return run ? {m_hi, low} : 64'h0;
  endfunction

  // Drive on the falling edge, check at the next falling edge.
  task automatic step(input string req, input logic t, input logic r,
                      input logic run, input logic [31:0] low);
    logic [63:0] exp;
    tick_i = t; rd_req_i = r; run_i = run; cnt_low_i = low;
    exp = model(t, r, run, low);
    if (r) m_last = exp;
    @(negedge clk_i);
    chk({req, " valid"}, {63'h0, rd_valid_o}, {63'h0, r});
    chk({req, " data"}, rd_data_o, m_last);
    tick_i = 1'b0; rd_req_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] low;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 valid", {63'h0, rd_valid_o}, 64'h0);
    chk("R1 data", rd_data_o, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2: first read of a high value yields no increment
    step("R2", 1'b0, 1'b1, 1'b1, 32'hFFFF_FFF0);
    chk("R2 hi", {32'h0, rd_data_o[63:32]}, 64'h0);
    // R3: strictly smaller wraps
    step("R3", 1'b0, 1'b1, 1'b1, 32'd3);
    chk("R3 hi", {32'h0, rd_data_o[63:32]}, 64'h1);
    // R3: equal value does not wrap
    step("R3 eq", 1'b0, 1'b1, 1'b1, 32'd3);
    chk("R3 eq hi", {32'h0, rd_data_o[63:32]}, 64'h1);
    // R8: idle cycle holds data, no valid
    step("R8 idle", 1'b0, 1'b0, 1'b1, 32'd9);
    // R5: tick-only wrap, then read
    step("R5 tick", 1'b0, 1'b0, 1'b1, 32'h8000_0000);
    step("R5 tick", 1'b1, 1'b0, 1'b1, 32'd1);
    step("R5 read", 1'b0, 1'b1, 1'b1, 32'd10);
    chk("R5 hi", {32'h0, rd_data_o[63:32]}, 64'h2);
    // R6: tick and read together count one wrap
    step("R6 both", 1'b1, 1'b1, 1'b1, 32'd2);
    chk("R6 hi", {32'h0, rd_data_o[63:32]}, 64'h3);
    step("R6 after", 1'b0, 1'b1, 1'b1, 32'd2);
    chk("R6 after hi", {32'h0, rd_data_o[63:32]}, 64'h3);
    // R7: not started returns zero and leaves tracking untouched
    step("R7 tick", 1'b1, 1'b0, 1'b0, 32'd0);
    step("R7 read", 1'b0, 1'b1, 1'b0, 32'd1);
    chk("R7 zero", rd_data_o, 64'h0);
    step("R7 resume", 1'b0, 1'b1, 1'b1, 32'd5);
    chk("R7 resume", rd_data_o, {32'd3, 32'd5});
    // R4: back-to-back reads, random mix
    low = 32'd5;
    for (int i = 0; i < 400; i++) begin
      logic t, r, run;
      low = low + $urandom_range(0, 32'h4000_0000);
      t   = ($urandom_range(0, 3) == 0);
      r   = ($urandom_range(0, 1) == 0);
      run = ($urandom_range(0, 15) != 0);
      step("R4 rand", t, r, run, low);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule